// File: doc/BRIEF.md
# Narrow Classic-to-Pipelined Bus Bridge

This bridge connects a 32-bit DMA master that uses classic (non-pipelined) Wishbone handshaking to a 64-bit interconnect that uses pipelined Wishbone handshaking. It sits in front of the main master arbiter. The master holds `n_cyc`/`n_stb` and its request until it sees `n_ack`. The bridge turns that held request into exactly one pipelined strobe on the wide side, and it converts the width in both directions.

On the way in, the request is registered. Write data is copied into both 32-bit halves of the wide bus. The four byte selects are placed in the half picked by byte-address bit 2, and the wide address is the master address with its three low bits cleared. On the way out, the slave acknowledge and the chosen 32-bit half of the read data are registered before they reach the master. This buys timing margin at a cost of two cycles of latency. Only one transfer is in flight at any time.

Top module: `wbb_narrow_bridge`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `w_cyc`, `w_stb` and `n_ack` are low.
- R2: Each classic transfer produces exactly one accepted wide strobe. `w_stb` stays high with unchanged request fields while `w_stall` is high, and it is low in the cycle after a cycle in which `w_stb` was high and `w_stall` low.
- R3: `w_stb` is never high without `w_cyc`. `w_cyc` stays high from the first strobe cycle until the cycle in which `w_ack` is sampled.
- R4: `w_adr` equals `n_adr` with bits 2:0 forced to zero, and `w_we` equals `n_we`.
- R5: `w_dat_w[63:32]` and `w_dat_w[31:0]` both equal `n_dat_w`.
- R6: When `n_adr[2]` is 1, `w_sel[7:4]` = `n_sel` and `w_sel[3:0]` = 0. When `n_adr[2]` is 0, `w_sel[3:0]` = `n_sel` and `w_sel[7:4]` = 0.
- R7: `n_ack` is high for exactly one cycle, the cycle right after the one in which `w_ack` is sampled high during a transfer. This includes an acknowledge given in the same cycle that the strobe is accepted.
- R8: During the `n_ack` cycle of a read, `n_dat_r` equals `w_dat_r[63:32]` if `n_adr[2]` was 1 and `w_dat_r[31:0]` otherwise, taken from the acknowledge cycle.
- R9: No new transfer starts before `n_ack` has been given. The request still held by the master during its `n_ack` cycle is not issued again, and `w_cyc` is low in the `n_ack` cycle and in the cycle after it.
- R10: A `w_ack` that arrives while no transfer is open produces no `n_ack` and opens no wide cycle.
- R11: From idle, `w_stb` rises in the cycle right after the first cycle in which `n_cyc` and `n_stb` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| n_cyc | input | 1 | Narrow master cycle |
| n_stb | input | 1 | Narrow master strobe (classic, held until ack) |
| n_we | input | 1 | Narrow master write enable |
| n_adr | input | 32 | Narrow master byte address |
| n_dat_w | input | 32 | Narrow master write data |
| n_sel | input | 4 | Narrow master byte selects |
| n_dat_r | output | 32 | Read data returned to the master |
| n_ack | output | 1 | Acknowledge to the master |
| w_cyc | output | 1 | Wide bus cycle |
| w_stb | output | 1 | Wide bus strobe (pipelined) |
| w_we | output | 1 | Wide bus write enable |
| w_adr | output | 32 | Wide bus byte address, 8-byte aligned |
| w_dat_w | output | 64 | Wide bus write data |
| w_sel | output | 8 | Wide bus byte selects |
| w_dat_r | input | 64 | Wide bus read data |
| w_ack | input | 1 | Wide bus acknowledge |
| w_stall | input | 1 | Wide bus stall |

## Verification
The bench targets several corner cases:
- Long stall runs. A bridge that drops or re-raises the strobe during a stall shows up there as a missing or doubled strobe.
- An acknowledge in the same cycle as strobe acceptance. A bridge that only listens for the acknowledge after acceptance hangs or acknowledges late.
- Back-to-back requests where the master keeps its strobe high through its own acknowledge cycle. A bridge that re-samples the old request there issues a second wide strobe.
- Stray acknowledges while idle, which must not leak through as `n_ack`.
- Both address halves, with zero and full byte selects. A wrong lane choice puts the selects or read data in the wrong half.

// File: rtl/wbb_pkg.sv
`timescale 1ns/1ps
package wbb_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned NARROW_W   = 32;
    localparam int unsigned WIDE_W     = 64;
    localparam int unsigned NSEL_W     = NARROW_W / 8;
    localparam int unsigned WSEL_W     = WIDE_W / 8;
    localparam int unsigned LANES      = WIDE_W / NARROW_W;
    localparam int unsigned LANE_W     = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned LANE_LSB   = $clog2(NSEL_W);
    localparam int unsigned WIDE_OFF_W = $clog2(WSEL_W);

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } xfer_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]   adr;
        logic                we;
        logic [NARROW_W-1:0] dat;
        logic [NSEL_W-1:0]   sel;
    } narrow_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] adr;
        logic              we;
        logic [WIDE_W-1:0] dat;
        logic [WSEL_W-1:0] sel;
        lane_t             lane;
    } wide_req_t;

    // Which narrow half of the wide word a byte address falls in.
    function automatic lane_t lane_of(input logic [ADDR_W-1:0] a);
        return a[LANE_LSB +: LANE_W];
    endfunction

    // Byte address rounded down to a wide-word boundary.
    function automatic logic [ADDR_W-1:0] align_wide(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        m = '1;
        m[WIDE_OFF_W-1:0] = '0;
        return a & m;
    endfunction

endpackage

// File: rtl/wbb_lane_steer.sv
`timescale 1ns/1ps
module wbb_lane_steer
    import wbb_pkg::*;
(
    input  narrow_req_t nreq,
    output wide_req_t   wreq
);

    lane_t             lane;
    logic [WIDE_W-1:0] dat_rep;
    logic [WSEL_W-1:0] sel_pos;

    assign lane = lane_of(nreq.adr);

    // Data goes to every lane; selects only to the addressed one.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dat_rep[g*NARROW_W +: NARROW_W] = nreq.dat;
        assign sel_pos[g*NSEL_W +: NSEL_W]     = (lane == lane_t'(g)) ? nreq.sel : '0;
    end

    always_comb begin
        wreq.adr  = align_wide(nreq.adr);
        wreq.we   = nreq.we;
        wreq.dat  = dat_rep;
        wreq.sel  = sel_pos;
        wreq.lane = lane;
    end

endmodule

// File: rtl/wbb_lane_pick.sv
`timescale 1ns/1ps
module wbb_lane_pick
    import wbb_pkg::*;
(
    input  logic [WIDE_W-1:0]   wide,
    input  lane_t               lane,
    output logic [NARROW_W-1:0] narrow
);

    logic [NARROW_W-1:0] parts [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_part
        assign parts[g] = wide[g*NARROW_W +: NARROW_W];
    end

    always_comb narrow = parts[lane];

endmodule

// File: rtl/wbb_req_ctrl.sv
`timescale 1ns/1ps
module wbb_req_ctrl
    import wbb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      n_cyc,
    input  logic      n_stb,
    input  wide_req_t wreq_in,
    input  logic      w_stall,
    input  logic      w_ack,
    output logic      w_cyc,
    output logic      w_stb,
    output wide_req_t req_q,
    output logic      ack_window
);

    xfer_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (n_cyc && n_stb) begin
                        req_q <= wreq_in;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (!w_stall) state <= w_ack ? ST_RESP : ST_WAIT;
                end
                ST_WAIT: begin
                    if (w_ack) state <= ST_RESP;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign w_stb      = (state == ST_ISSUE);
    assign w_cyc      = (state == ST_ISSUE) || (state == ST_WAIT);
    assign ack_window = ((state == ST_ISSUE) && !w_stall) || (state == ST_WAIT);

    // R2: an accepted strobe is withdrawn on the next cycle
    p_stb_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (w_stb && !w_stall) |=> !w_stb)
        else $error("strobe held after acceptance");

    // R2: a stalled strobe stays up with the same request
    p_stb_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (w_stb && w_stall) |=> (w_stb && $stable(req_q)))
        else $error("stalled strobe not held");

    // R3: strobe only inside a cycle
    p_stb_in_cyc_r3: assert property (@(posedge clk) disable iff (rst)
        w_stb |-> w_cyc)
        else $error("strobe outside cycle");

endmodule

// File: rtl/wbb_rsp_stage.sv
`timescale 1ns/1ps
module wbb_rsp_stage
    import wbb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ack_window,
    input  logic                w_ack,
    input  logic [WIDE_W-1:0]   w_dat_r,
    input  lane_t               lane,
    output logic                n_ack,
    output logic [NARROW_W-1:0] n_dat_r
);

    logic [NARROW_W-1:0] picked;

    wbb_lane_pick u_pick (
        .wide   (w_dat_r),
        .lane   (lane),
        .narrow (picked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            n_ack   <= 1'b0;
            n_dat_r <= '0;
        end else begin
            n_ack <= ack_window && w_ack;
            if (ack_window && w_ack) n_dat_r <= picked;
        end
    end

    // R7: the master acknowledge is a single-cycle pulse
    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        n_ack |=> !n_ack)
        else $error("master ack longer than one cycle");

endmodule

// File: rtl/wbb_narrow_bridge.sv
`timescale 1ns/1ps
module wbb_narrow_bridge
    import wbb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                n_cyc,
    input  logic                n_stb,
    input  logic                n_we,
    input  logic [ADDR_W-1:0]   n_adr,
    input  logic [NARROW_W-1:0] n_dat_w,
    input  logic [NSEL_W-1:0]   n_sel,
    output logic [NARROW_W-1:0] n_dat_r,
    output logic                n_ack,
    output logic                w_cyc,
    output logic                w_stb,
    output logic                w_we,
    output logic [ADDR_W-1:0]   w_adr,
    output logic [WIDE_W-1:0]   w_dat_w,
    output logic [WSEL_W-1:0]   w_sel,
    input  logic [WIDE_W-1:0]   w_dat_r,
    input  logic                w_ack,
    input  logic                w_stall
);

    narrow_req_t nreq;
    wide_req_t   wreq;
    wide_req_t   req_q;
    logic        ack_window;

    always_comb begin
        nreq.adr = n_adr;
        nreq.we  = n_we;
        nreq.dat = n_dat_w;
        nreq.sel = n_sel;
    end

    wbb_lane_steer u_steer (
        .nreq (nreq),
        .wreq (wreq)
    );

    wbb_req_ctrl u_req (
        .clk        (clk),
        .rst        (rst),
        .n_cyc      (n_cyc),
        .n_stb      (n_stb),
        .wreq_in    (wreq),
        .w_stall    (w_stall),
        .w_ack      (w_ack),
        .w_cyc      (w_cyc),
        .w_stb      (w_stb),
        .req_q      (req_q),
        .ack_window (ack_window)
    );

    wbb_rsp_stage u_rsp (
        .clk        (clk),
        .rst        (rst),
        .ack_window (ack_window),
        .w_ack      (w_ack),
        .w_dat_r    (w_dat_r),
        .lane       (req_q.lane),
        .n_ack      (n_ack),
        .n_dat_r    (n_dat_r)
    );

    assign w_we    = req_q.we;
    assign w_adr   = req_q.adr;
    assign w_dat_w = req_q.dat;
    assign w_sel   = req_q.sel;

    // R7: every master ack is caused by a slave ack one cycle earlier
    p_ack_cause_r7: assert property (@(posedge clk) disable iff (rst)
        n_ack |-> $past(w_ack))
        else $error("master ack without slave ack");

    // R9: the wide side is closed while and just after the master is acked
    p_quiet_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
        n_ack |-> (!w_cyc ##1 !w_cyc))
        else $error("wide cycle open around master ack");

endmodule

// File: tb/sim_wbb_narrow_bridge.sv
`timescale 1ns/1ps
module sim_wbb_narrow_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        n_cyc, n_stb, n_we;
    logic [31:0] n_adr, n_dat_w;
    logic [3:0]  n_sel;
    logic [31:0] n_dat_r;
    logic        n_ack;
    logic        w_cyc, w_stb, w_we;
    logic [31:0] w_adr;
    logic [63:0] w_dat_w;
    logic [7:0]  w_sel;
    logic [63:0] w_dat_r;
    logic        w_ack, w_stall;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wbb_narrow_bridge u0 (
        .clk(clk), .rst(rst),
        .n_cyc(n_cyc), .n_stb(n_stb), .n_we(n_we), .n_adr(n_adr),
        .n_dat_w(n_dat_w), .n_sel(n_sel), .n_dat_r(n_dat_r), .n_ack(n_ack),
        .w_cyc(w_cyc), .w_stb(w_stb), .w_we(w_we), .w_adr(w_adr),
        .w_dat_w(w_dat_w), .w_sel(w_sel), .w_dat_r(w_dat_r),
        .w_ack(w_ack), .w_stall(w_stall)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_adr(input logic [31:0] a);
        return {a[31:3], 3'b000};
    endfunction

    function automatic logic [7:0] exp_sel(input logic [31:0] a, input logic [3:0] s);
        return a[2] ? {s, 4'h0} : {4'h0, s};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] a, input logic [63:0] d);
        return a[2] ? d[63:32] : d[31:0];
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One classic transfer; entered and left at a negedge.
    task automatic do_xfer(input logic [31:0] adr, input logic we, input logic [31:0] wd,
                           input logic [3:0] sel, input int stall_n, input int lat,
                           input logic [63:0] rd);
        int  strobes;
        int  stalls_left;
        int  cnt;
        int  ack_t;
        int  t;
        bit  done;
        strobes = 0; stalls_left = stall_n; cnt = -1; ack_t = -100; t = 0; done = 1'b0;
        n_cyc = 1'b1; n_stb = 1'b1; n_adr = adr; n_we = we; n_dat_w = wd; n_sel = sel;
        while (!done && t < 64) begin
            w_ack = 1'b0; w_stall = 1'b0; w_dat_r = {$urandom, $urandom};
            if (t == 0) chk(!w_stb, "R11 no strobe in request cycle", 64'(w_stb), 64'd0);
            if (t == 1) chk(w_stb, "R11 strobe next cycle", 64'(w_stb), 64'd1);
            if (n_ack) begin
                chk(ack_t == t - 1, "R7 ack one cycle after slave ack", 64'(t), 64'(ack_t + 1));
                if (!we) chk(n_dat_r == exp_rd(adr, rd), "R8 read half", 64'(n_dat_r), 64'(exp_rd(adr, rd)));
                chk(strobes == 1, "R2 single strobe", 64'(strobes), 64'd1);
                chk(!w_cyc, "R9 cycle closed at ack", 64'(w_cyc), 64'd0);
                done = 1'b1;
            end else begin
                if (t != ack_t + 1 || ack_t < 0)
                    chk(1'b1, "R7", 64'd0, 64'd0);
                if (ack_t >= 0 && t == ack_t + 1)
                    chk(1'b0, "R7 ack missing", 64'(n_ack), 64'd1);
                if (w_stb) begin
                    chk(w_cyc, "R3 strobe inside cycle", 64'(w_cyc), 64'd1);
                    chk(w_adr == exp_adr(adr) && w_we == we, "R4 address/we",
                        {31'd0, w_we, w_adr}, {31'd0, we, exp_adr(adr)});
                    chk(w_dat_w == {wd, wd}, "R5 data replicated", w_dat_w, {wd, wd});
                    chk(w_sel == exp_sel(adr, sel), "R6 select half", 64'(w_sel), 64'(exp_sel(adr, sel)));
                    if (stalls_left > 0) begin
                        w_stall = 1'b1;
                        stalls_left--;
                    end else begin
                        strobes++;
                        cnt = lat;
                    end
                end
                if (cnt == 0) begin
                    w_ack = 1'b1; w_dat_r = rd; ack_t = t; cnt = -1;
                end else if (cnt > 0) begin
                    chk(w_cyc, "R3 cycle held until ack", 64'(w_cyc), 64'd1);
                    cnt--;
                end
            end
            step();
            t++;
        end
        if (!done) chk(1'b0, "R7 transfer timed out", 64'd0, 64'd1);
        w_ack = 1'b0; w_stall = 1'b0;
        chk(!n_ack, "R7 ack single cycle", 64'(n_ack), 64'd0);
        chk(!w_cyc, "R9 no reissue after ack", 64'(w_cyc), 64'd0);
    endtask

    task automatic idle_gap(input int n, input bit stray);
        n_cyc = 1'b0; n_stb = 1'b0; n_adr = $urandom;
        for (int i = 0; i < n; i++) begin
            w_ack = stray && (i == 0);
            w_dat_r = {$urandom, $urandom};
            step();
            w_ack = 1'b0;
            chk(!n_ack, "R10 stray ack ignored", 64'(n_ack), 64'd0);
            chk(!w_cyc, "R10 no cycle when idle", 64'(w_cyc), 64'd0);
        end
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        rst = 1'b1; n_cyc = 1'b0; n_stb = 1'b0; n_we = 1'b0; n_adr = '0;
        n_dat_w = '0; n_sel = '0; w_dat_r = '0; w_ack = 1'b0; w_stall = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!w_cyc && !w_stb && !n_ack, "R1 quiet in reset",
            {61'd0, w_cyc, w_stb, n_ack}, 64'd0);
        rst = 1'b0;
        step();
        chk(!w_cyc && !w_stb && !n_ack, "R1 quiet after reset",
            {61'd0, w_cyc, w_stb, n_ack}, 64'd0);

        // directed corners
        do_xfer(32'h0000_1000, 1'b1, 32'hA5A5_1234, 4'hF, 0, 1, 64'd0);          // R6 lower half
        do_xfer(32'h0000_1004, 1'b1, 32'hDEAD_BEEF, 4'h3, 0, 1, 64'd0);          // R6 upper half
        do_xfer(32'h0000_2000, 1'b0, 32'h0, 4'hF, 0, 2, 64'h1111_2222_3333_4444); // R8 lower
        do_xfer(32'h0000_2004, 1'b0, 32'h0, 4'hF, 0, 2, 64'h5555_6666_7777_8888); // R8 upper
        do_xfer(32'hFFFF_FFFC, 1'b0, 32'h0, 4'h0, 5, 0, 64'hCAFE_F00D_0BAD_CAFE); // R2 stall, R7 same-cycle ack
        do_xfer(32'h0000_0007, 1'b1, 32'h0102_0304, 4'h0, 0, 0, 64'd0);          // R6 zero selects
        idle_gap(3, 1'b1);                                                       // R10
        do_xfer(32'h0000_3000, 1'b0, 32'h0, 4'h1, 2, 3, 64'h0123_4567_89AB_CDEF);
        do_xfer(32'h0000_3004, 1'b0, 32'h0, 4'h8, 0, 0, 64'hFEDC_BA98_7654_3210); // R9 back to back

        for (int i = 0; i < 300; i++) begin
            do_xfer($urandom, 1'($urandom % 2), $urandom, 4'($urandom % 16),
                    ($urandom % 3 == 0) ? int'($urandom % 5) : 0,
                    int'($urandom % 4), {$urandom, $urandom});
            if ($urandom % 3 == 0) idle_gap(int'($urandom % 3) + 1, 1'($urandom % 2));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule